// File: doc/BRIEF.md
# Random Generator Status Flags and Interrupt

This block keeps the status word of a random number generator. It holds five flags:
- A ready flag for the one-word output buffer.
- Two live error bits: one for the noise seed and one for the sampling clock.
- Two sticky error flags matching those live bits.

The same flags drive a single interrupt line.

The surrounding generator reports the following on single-cycle strobes and level inputs:
- a fresh random word entering the buffer;
- each read of the buffer;
- the live seed and clock error conditions;
- the control bits for interrupt enable and for turning off clock error detection.

Software reads the status word on a plain read bus, which has no handshake. It clears a sticky error flag by writing 0 to its bit. Writing 1 to that bit leaves the flag unchanged.

Each live error bit is a registered copy of its input condition. The clock condition is forced to 0 while clock error detection is turned off. A sticky flag is raised on the same clock edge as its live bit rises. It stays set after the condition goes away, until software clears it. A condition that is still present after such a clear does not raise the flag again. Only a new rising edge of the live bit does.

Top module: `rng_flag_unit`

## Requirements
- R1: After reset every status flag is 0, the status word reads 0 and `irq` is low.
- R2: A `newValue` strobe sets the ready flag (status bit 0) at the next clock edge. No other condition gates this.
- R3: A `dataRead` strobe clears the ready flag at the next edge. If `newValue` is high in the same cycle, the flag ends at 1.
- R4: Status bit 2 (seed error, live) shows the value `seedErrLive` had at the previous clock edge.
- R5: Status bit 1 (clock error, live) shows `clkErrLive` from the previous edge when `clkDetectOff` was 0 at that edge. It shows 0 when `clkDetectOff` was 1.
- R6: The sticky seed flag (bit 6) sets on the edge where bit 2 rises from 0 to 1. The sticky clock flag (bit 5) sets on the edge where bit 1 rises. A live bit that stays high does not set its sticky flag again.
- R7: A status write with 0 in bit 5 or bit 6 clears that sticky flag at the next edge. A 1 in that bit leaves the flag unchanged.
- R8: When a sticky flag's set event and a clearing write fall in the same cycle, the flag ends at 1.
- R9: Write data in bits 0, 1, 2 and in every bit other than 5 and 6 has no effect on any flag.
- R10: `irq` is high exactly when `irqEnable` is 1 and at least one of the ready flag and the two sticky flags is 1. It follows `irqEnable` in the same cycle.
- R11: Status bits 3, 4 and 7 up to `STAT_W-1` always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| newValue | input | 1 | Strobe: a new random word was loaded into the buffer |
| dataRead | input | 1 | Strobe: the buffer data word was read |
| seedErrLive | input | 1 | Live seed error condition from the noise checker |
| clkErrLive | input | 1 | Live clock error condition from the clock monitor |
| clkDetectOff | input | 1 | Control bit: 1 turns clock error detection off |
| irqEnable | input | 1 | Control bit: global interrupt enable |
| statWrite | input | 1 | Strobe: write to the status word |
| statWdata | input | STAT_W | Status write data |
| statRdata | output | STAT_W | Status word read value |
| irq | output | 1 | Interrupt request, level |

## Verification
The assertions take for granted that `newValue`, `dataRead` and `statWrite` are single-cycle pulses, synchronous to `clk`. They also assume the live error levels are already synchronized to `clk`, since the block samples them directly. The stimulus changes every input two nanoseconds after a rising edge. It holds each strobe for exactly one cycle, so no input moves near a sampling edge. Where the scenarios put a set event and a clearing write in one cycle, both inputs are driven at the same instant. The priority check then does not depend on any ordering inside the cycle.

// File: rtl/rng_flag_pkg.sv
package rng_flag_pkg;

  // Status word bit positions; software decodes these.
  localparam int READY_BIT   = 0;
  localparam int CLKCUR_BIT  = 1;
  localparam int SEEDCUR_BIT = 2;
  localparam int CLKINT_BIT  = 5;
  localparam int SEEDINT_BIT = 6;

  // Error channels: index 0 is the clock monitor, index 1 the seed checker.
  localparam int N_ERR    = 2;
  localparam int ERR_CLK  = 0;
  localparam int ERR_SEED = 1;

  function automatic int curBitOf(input int ch);
    return (ch == ERR_CLK) ? CLKCUR_BIT : SEEDCUR_BIT;
  endfunction

  function automatic int intBitOf(input int ch);
    return (ch == ERR_CLK) ? CLKINT_BIT : SEEDINT_BIT;
  endfunction

  // Strobes from control to the flag datapath, one cycle each.
  typedef struct packed {
    logic             setReady;
    logic             clrReady;
    logic [N_ERR-1:0] errLive;   // masked live conditions
    logic [N_ERR-1:0] setErr;    // rising edge of a live bit
    logic [N_ERR-1:0] clrErr;    // write of 0 to a sticky bit
  } flagStrobes_t;

endpackage

// File: rtl/rng_flag_ctrl.sv
module rng_flag_ctrl
  import rng_flag_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input  logic              newValue,
  input  logic              dataRead,
  input  logic              seedErrLive,
  input  logic              clkErrLive,
  input  logic              clkDetectOff,
  input  logic              statWrite,
  input  logic [STAT_W-1:0] statWdata,
  input  logic [N_ERR-1:0]  errCur,
  output flagStrobes_t      strb
);

  logic unusedWdata;
  assign unusedWdata = ^statWdata;

  always_comb begin
    strb = '0;
    strb.setReady = newValue;
    strb.clrReady = dataRead;
    strb.errLive[ERR_CLK]  = clkErrLive & ~clkDetectOff;
    strb.errLive[ERR_SEED] = seedErrLive;
    for (int ch = 0; ch < N_ERR; ch++) begin
      strb.setErr[ch] = strb.errLive[ch] & ~errCur[ch];
      strb.clrErr[ch] = statWrite & ~statWdata[intBitOf(ch)];
    end
  end

endmodule

// File: rtl/rng_flag_dpath.sv
module rng_flag_dpath
  import rng_flag_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  flagStrobes_t      strb,
  input  logic              irqEnable,
  output logic [N_ERR-1:0]  errCur,
  output logic [STAT_W-1:0] statRdata,
  output logic              irq
);

  logic             dataReady;
  logic [N_ERR-1:0] errInt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dataReady <= 1'b0;
    else if (strb.setReady) dataReady <= 1'b1;
    else if (strb.clrReady) dataReady <= 1'b0;
  end

  // R3
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrReady && !strb.setReady) |=> !dataReady);

  for (genvar ch = 0; ch < N_ERR; ch++) begin : g_err
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        errCur[ch] <= 1'b0;
        errInt[ch] <= 1'b0;
      end else begin
        errCur[ch] <= strb.errLive[ch];
        if (strb.setErr[ch])      errInt[ch] <= 1'b1;   // set beats clear
        else if (strb.clrErr[ch]) errInt[ch] <= 1'b0;
      end
    end

    // R6
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.setErr[ch] |=> (errInt[ch] && errCur[ch]));

    // R7
    sticky_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.clrErr[ch] && !strb.setErr[ch]) |=> !errInt[ch]);

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.clrErr[ch] && !strb.setErr[ch]) |=> $stable(errInt[ch]));
  end

  always_comb begin
    statRdata = '0;
    statRdata[READY_BIT] = dataReady;
    for (int ch = 0; ch < N_ERR; ch++) begin
      statRdata[curBitOf(ch)] = errCur[ch];
      statRdata[intBitOf(ch)] = errInt[ch];
    end
  end

  assign irq = irqEnable & (dataReady | (|errInt));

endmodule

// File: rtl/rng_flag_unit.sv
module rng_flag_unit
  import rng_flag_pkg::*;
#(
  parameter int STAT_W = 32   // must be at least 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              newValue,
  input  logic              dataRead,
  input  logic              seedErrLive,
  input  logic              clkErrLive,
  input  logic              clkDetectOff,
  input  logic              irqEnable,
  input  logic              statWrite,
  input  logic [STAT_W-1:0] statWdata,
  output logic [STAT_W-1:0] statRdata,
  output logic              irq
);

  flagStrobes_t     strb;
  logic [N_ERR-1:0] errCur;

  rng_flag_ctrl #(.STAT_W(STAT_W)) i_ctrl (
    .newValue    (newValue),
    .dataRead    (dataRead),
    .seedErrLive (seedErrLive),
    .clkErrLive  (clkErrLive),
    .clkDetectOff(clkDetectOff),
    .statWrite   (statWrite),
    .statWdata   (statWdata),
    .errCur      (errCur),
    .strb        (strb)
  );

  rng_flag_dpath #(.STAT_W(STAT_W)) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .irqEnable(irqEnable),
    .errCur   (errCur),
    .statRdata(statRdata),
    .irq      (irq)
  );

  // R2
  ready_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    newValue |=> statRdata[READY_BIT]);

  // R5
  clk_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkDetectOff |=> !statRdata[CLKCUR_BIT]);

  // R4
  seed_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    seedErrLive |=> statRdata[SEEDCUR_BIT]);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqEnable |-> !irq);

endmodule

// File: tb/test_rng_flag_unit.sv
module test_rng_flag_unit;

  localparam int STAT_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              newValue = 1'b0;
  logic              dataRead = 1'b0;
  logic              seedErrLive = 1'b0;
  logic              clkErrLive = 1'b0;
  logic              clkDetectOff = 1'b0;
  logic              irqEnable = 1'b0;
  logic              statWrite = 1'b0;
  logic [STAT_W-1:0] statWdata = '0;
  logic [STAT_W-1:0] statRdata;
  logic              irq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rng_flag_unit #(.STAT_W(STAT_W)) i_rng_flag_unit (
    .clk(clk), .rstN(rstN), .newValue(newValue), .dataRead(dataRead),
    .seedErrLive(seedErrLive), .clkErrLive(clkErrLive),
    .clkDetectOff(clkDetectOff), .irqEnable(irqEnable),
    .statWrite(statWrite), .statWdata(statWdata),
    .statRdata(statRdata), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic checkVal(input string req, input logic [STAT_W-1:0] act,
                          input logic [STAT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulseWrite(input logic [STAT_W-1:0] d);
    statWrite = 1'b1; statWdata = d;
    tick();
    statWrite = 1'b0; statWdata = '0;
  endtask

  task automatic t_reset();
    checkVal("R1 status after reset", statRdata, 32'h0);
    checkVal("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_ready();
    newValue = 1'b1; tick(); newValue = 1'b0;
    checkVal("R2 ready set", statRdata, 32'h1);
    checkVal("R10 irq off when disabled", {31'b0, irq}, 32'h0);
    irqEnable = 1'b1; #1;
    checkVal("R10 irq from ready", {31'b0, irq}, 32'h1);
    irqEnable = 1'b0; #1;
    dataRead = 1'b1; tick(); dataRead = 1'b0;
    checkVal("R3 ready cleared by read", statRdata, 32'h0);
    newValue = 1'b1; dataRead = 1'b1; tick();
    newValue = 1'b0; dataRead = 1'b0;
    checkVal("R3 load with read keeps ready", statRdata, 32'h1);
    dataRead = 1'b1; tick(); dataRead = 1'b0;
    checkVal("R3 ready cleared again", statRdata, 32'h0);
  endtask

  task automatic t_seed();
    seedErrLive = 1'b1; tick();
    checkVal("R4 R6 seed live and sticky", statRdata, 32'h44);
    pulseWrite(32'h0);
    checkVal("R7 R6 clear with condition still live", statRdata, 32'h04);
    tick();
    checkVal("R6 no re-set while live stays high", statRdata, 32'h04);
    seedErrLive = 1'b0; tick();
    checkVal("R4 seed live falls", statRdata, 32'h0);
  endtask

  task automatic t_clk();
    clkDetectOff = 1'b1; clkErrLive = 1'b1; tick();
    checkVal("R5 clock error masked", statRdata, 32'h0);
    clkDetectOff = 1'b0; tick();
    checkVal("R5 R6 clock live and sticky", statRdata, 32'h22);
    pulseWrite(32'hFFFF_FFFF);
    checkVal("R7 R9 write ones keeps flags", statRdata, 32'h22);
    pulseWrite(32'h0);
    checkVal("R7 R9 write zero clears sticky only", statRdata, 32'h02);
    clkErrLive = 1'b0; tick();
    checkVal("R5 clock live falls", statRdata, 32'h0);
  endtask

  task automatic t_collide();
    seedErrLive = 1'b1; statWrite = 1'b1; statWdata = '0; tick();
    statWrite = 1'b0;
    checkVal("R8 set beats clear", statRdata, 32'h44);
    irqEnable = 1'b1; #1;
    checkVal("R10 irq from sticky seed", {31'b0, irq}, 32'h1);
    seedErrLive = 1'b0; pulseWrite(32'h0);
    checkVal("R7 sticky seed cleared", statRdata, 32'h0);
    checkVal("R10 irq drops with flags clear", {31'b0, irq}, 32'h0);
    irqEnable = 1'b0;
  endtask

  task automatic t_readonly();
    pulseWrite(32'hFFFF_FFFF);
    checkVal("R9 R11 write ones from zero", statRdata, 32'h0);
    newValue = 1'b1; tick(); newValue = 1'b0;
    pulseWrite(32'h0);
    checkVal("R9 ready ignores write zero", statRdata, 32'h1);
    seedErrLive = 1'b1; clkErrLive = 1'b1; tick();
    seedErrLive = 1'b0; clkErrLive = 1'b0;
    checkVal("R11 reserved bits zero with all flags", statRdata, 32'h67);
    tick();
    checkVal("R11 sticky remain after live drop", statRdata, 32'h61);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    #1;
    t_reset();
    t_ready();
    t_seed();
    t_clk();
    t_collide();
    t_readonly();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule